// File: doc/BRIEF.md
# Infrared Manchester Frame Decoder

This block takes an infrared receiver line that rests high and has already been demodulated, and turns one Manchester-coded remote-control frame into a system address and a command code. A prescaler inside the block divides the system clock into a slow tick of roughly 64 us. Two counters run on that tick. A fine counter times individual line phases. A coarse counter moves up once every 256 fine ticks and bounds how long a whole detection attempt may last.

A detection attempt starts by waiting until the line has been quiet (high) for long enough. The block then waits for the falling edge that opens a frame. It measures the low phase that follows and uses that length as its half-bit time T. From T it derives two thresholds: a sample point at three quarters of a bit and an edge deadline at five quarters of a bit. It then shifts in twelve bits. After each bit it realigns its timer on the transition in the middle of that bit. A good frame ends with a one-clock done pulse. Any timing violation ends with a one-clock fault pulse and both result bytes at all ones. In either case the block goes straight back to waiting for a quiet line.

Top module: `ir_frame_decoder`

## Requirements
- R1: After a synchronous reset, `cmd_code` and `sys_code` are 0 and neither `frame_done` nor `frame_fault` is high.
- R2: A frame is accepted only after the line has stayed high for 55 consecutive fine ticks. Any low level during that wait restarts the count, so a frame that starts too soon after a break yields neither done nor fault.
- R3: If the quiet line, or the falling edge that follows it, has not been seen when the coarse counter reaches 8 (2048 fine ticks after the attempt began), `frame_fault` pulses. This holds whether the line is stuck low or stuck high.
- R4: If the first low phase reaches 17 fine ticks, the block faults. Otherwise its length in ticks becomes the half-bit time T.
- R5: The high phase after that low phase must end in a falling edge while the timer is still below T + floor(T/2). If it does not, the block faults.
- R6: Twelve bits are sampled once the timer reaches T + floor(T/2), with high read as 1 and low as 0. The first bit appears at `cmd_code[6]`. The next five, first arrival most significant, appear at `sys_code[4:0]`. The last six appear the same way at `cmd_code[5:0]`. `cmd_code[7]` and `sys_code[7:5]` are 0.
- R7: After each sample, the opposite edge (falling after a 1, rising after a 0) must come while the timer is still below 2T + floor(T/2). If it does not, the block faults. If it does, the timer restarts on that edge.
- R8: On every fault, `frame_fault` is high for one clock and both `cmd_code` and `sys_code` read 0xFF.
- R9: `frame_done` is high for exactly one clock. It is never high together with `frame_fault`. The outputs change only in a done or fault cycle and hold their value until the next one.
- R10: Frames with half-bit times of 8 to 16 fine ticks decode without reconfiguration. Frames sent back to back are all decoded, because the block re-arms by itself after each result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ir_line | input | 1 | Demodulated infrared line, high when idle, asynchronous |
| cmd_code | output | 8 | Bit 6 toggle, bits 5:0 command, bit 7 zero; 0xFF after a fault |
| sys_code | output | 8 | Bits 4:0 system address, bits 7:5 zero; 0xFF after a fault |
| frame_done | output | 1 | One-clock pulse when a frame has been decoded |
| frame_fault | output | 1 | One-clock pulse when an attempt fails |

## Verification
The assertions check the following on every cycle: result and fault pulses never coincide, a done pulse lasts one clock, a fault presents 0xFF on both bytes, a done presents clean upper bits, and the outputs hold between results. The timing rules can only be shown by the bench's scenarios, which drive chosen waveforms. These rules are quiet-line qualification with restart on a break, the 2048-tick detection limit, the start-bit length and start-high limits, the mid-bit edge deadline, and the learned half-bit time across a range of periods. The bench also builds the field layout from random toggle, address and command values.

// File: rtl/irdec_pkg.sv
// Shared widths and state encoding for the infrared frame decoder.
// Assumes a frame of one toggle bit, SYS_W address bits and CMD_W command bits.
package irdec_pkg;
    localparam int SYS_W  = 5;
    localparam int CMD_W  = 6;
    localparam int N_BITS = 1 + SYS_W + CMD_W;
    localparam int OUT_W  = 8;

    typedef enum logic [2:0] {
        S_HUNT     = 3'd0,
        S_ARM      = 3'd1,
        S_START_LO = 3'd2,
        S_START_HI = 3'd3,
        S_SAMPLE   = 3'd4,
        S_MIDEDGE  = 3'd5
    } dec_state_t;
endpackage

// File: rtl/irdec_sync.sv
// Brings the asynchronous infrared line into the clock domain.
// Assumes the line idles high, so every stage resets to 1.
module irdec_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain;

    // Shift the raw level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], din};
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/irdec_timebase.sv
// Tick prescaler plus the fine phase timer and the coarse attempt timer.
// Assumes CLKS_PER_TICK >= 2. Both timers saturate, so a long wait never wraps.
module irdec_timebase #(
    parameter int CLKS_PER_TICK = 256,
    parameter int FINE_W        = 8,
    parameter int SUB_W         = 8,
    parameter int COARSE_W      = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                fine_clr,
    input  logic                span_clr,
    output logic [FINE_W-1:0]   fine,
    output logic [COARSE_W-1:0] coarse
);
    localparam int PRE_W = $clog2(CLKS_PER_TICK);
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLKS_PER_TICK - 1);

    logic [PRE_W-1:0] pre;
    logic [SUB_W-1:0] sub;
    logic             tick;

    assign tick = (pre == PRE_LAST);

    // Free-running prescaler. The phase timers do not restart it.
    always_ff @(posedge clk) begin
        if (!rst_n)    pre <= '0;
        else if (tick) pre <= '0;
        else           pre <= pre + 1'b1;
    end

    // Fine timer: counts ticks since the last clear and holds at full scale.
    always_ff @(posedge clk) begin
        if (!rst_n)                     fine <= '0;
        else if (fine_clr)              fine <= '0;
        else if (tick && (fine != '1))  fine <= fine + 1'b1;
    end

    // Coarse timer: one step per 2**SUB_W ticks since the attempt began.
    always_ff @(posedge clk) begin
        if (!rst_n || span_clr) begin
            sub    <= '0;
            coarse <= '0;
        end else if (tick) begin
            sub <= sub + 1'b1;
            if ((sub == '1) && (coarse != '1)) coarse <= coarse + 1'b1;
        end
    end
endmodule

// File: rtl/irdec_fsm.sv
// Frame sequencer: quiet-line wait, start-bit measurement, threshold setup,
// bit sampling with mid-bit realignment, and the result/fault outputs.
// Assumes a synchronised line and the fine/coarse timers from irdec_timebase.
module irdec_fsm
    import irdec_pkg::*;
#(
    parameter int FINE_W       = 8,
    parameter int COARSE_W     = 4,
    parameter int IDLE_TICKS   = 55,
    parameter int START_MAX    = 17,
    parameter int COARSE_LIMIT = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                line,
    input  logic [FINE_W-1:0]   fine,
    input  logic [COARSE_W-1:0] coarse,
    output logic                fine_clr,
    output logic                span_clr,
    output logic [OUT_W-1:0]    cmd_code,
    output logic [OUT_W-1:0]    sys_code,
    output logic                frame_done,
    output logic                frame_fault
);
    localparam int REF_W = FINE_W + 2;
    localparam int CNT_W = $clog2(N_BITS + 1);
    localparam logic [FINE_W-1:0]   IDLE_LIM  = FINE_W'(IDLE_TICKS);
    localparam logic [FINE_W-1:0]   START_LIM = FINE_W'(START_MAX);
    localparam logic [COARSE_W-1:0] SPAN_LIM  = COARSE_W'(COARSE_LIMIT);

    dec_state_t        state, nxt;
    logic [REF_W-1:0]  fine_x, ref_smp, ref_edge;
    logic [N_BITS-1:0] shreg;
    logic [CNT_W-1:0]  bits_left;
    logic              last_bit;
    logic              timed_out;
    logic              cap, arm, shift, step, go_done, go_fault;
    logic [OUT_W-1:0]  cmd_nxt, sys_nxt;

    assign fine_x    = {2'b00, fine};
    assign timed_out = (coarse >= SPAN_LIM);

    // Next state and strobes. Each deadline is checked before the edge it guards.
    always_comb begin
        nxt      = state;
        fine_clr = 1'b0;
        span_clr = 1'b0;
        cap      = 1'b0;
        arm      = 1'b0;
        shift    = 1'b0;
        step     = 1'b0;
        go_done  = 1'b0;
        go_fault = 1'b0;
        unique case (state)
            S_HUNT: begin
                if (timed_out)             go_fault = 1'b1;
                else if (fine >= IDLE_LIM) nxt = S_ARM;
                else if (!line)            fine_clr = 1'b1;
            end
            S_ARM: begin
                if (timed_out) go_fault = 1'b1;
                else if (!line) begin
                    fine_clr = 1'b1;
                    nxt      = S_START_LO;
                end
            end
            S_START_LO: begin
                if (fine >= START_LIM) go_fault = 1'b1;
                else if (line) begin
                    cap      = 1'b1;
                    fine_clr = 1'b1;
                    nxt      = S_START_HI;
                end
            end
            S_START_HI: begin
                if (fine_x >= ref_smp) go_fault = 1'b1;
                else if (!line) begin
                    fine_clr = 1'b1;
                    arm      = 1'b1;
                    nxt      = S_SAMPLE;
                end
            end
            S_SAMPLE: begin
                if (fine_x >= ref_smp) begin
                    shift = 1'b1;
                    nxt   = S_MIDEDGE;
                end
            end
            S_MIDEDGE: begin
                if (fine_x >= ref_edge) go_fault = 1'b1;
                else if (line != last_bit) begin
                    fine_clr = 1'b1;
                    step     = 1'b1;
                    if (bits_left == CNT_W'(1)) go_done = 1'b1;
                    else                        nxt = S_SAMPLE;
                end
            end
            default: nxt = S_HUNT;
        endcase
        if (go_done || go_fault) begin
            nxt      = S_HUNT;
            fine_clr = 1'b1;
            span_clr = 1'b1;
        end
    end

    // Result bytes for a good frame: toggle above the command, address alone.
    always_comb begin
        cmd_nxt                = '0;
        cmd_nxt[CMD_W-1:0]     = shreg[CMD_W-1:0];
        cmd_nxt[CMD_W]         = shreg[N_BITS-1];
        sys_nxt                = '0;
        sys_nxt[SYS_W-1:0]     = shreg[CMD_W+SYS_W-1:CMD_W];
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_HUNT;
        else        state <= nxt;
    end

    // Thresholds learned from the measured half-bit time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ref_smp  <= '0;
            ref_edge <= '0;
        end else if (cap) begin
            ref_smp  <= fine_x + (fine_x >> 1);
            ref_edge <= (fine_x << 1) + (fine_x >> 1);
        end
    end

    // Bit shifter, last sampled level and remaining-bit count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            last_bit  <= 1'b0;
            bits_left <= '0;
        end else begin
            if (arm) begin
                shreg     <= '0;
                bits_left <= CNT_W'(N_BITS);
            end
            if (shift) begin
                shreg    <= {shreg[N_BITS-2:0], line};
                last_bit <= line;
            end
            if (step) bits_left <= bits_left - 1'b1;
        end
    end

    // Registered outputs: results on done, all ones on fault, otherwise held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code    <= '0;
            sys_code    <= '0;
            frame_done  <= 1'b0;
            frame_fault <= 1'b0;
        end else begin
            frame_done  <= go_done;
            frame_fault <= go_fault;
            if (go_done) begin
                cmd_code <= cmd_nxt;
                sys_code <= sys_nxt;
            end else if (go_fault) begin
                cmd_code <= '1;
                sys_code <= '1;
            end
        end
    end
endmodule

// File: rtl/ir_frame_decoder.sv
// Top level: synchroniser, time base and frame sequencer.
// Assumes ir_line is asynchronous, already demodulated and high when idle.
module ir_frame_decoder
    import irdec_pkg::*;
#(
    parameter int CLKS_PER_TICK = 256,
    parameter int SYNC_STAGES   = 2,
    parameter int FINE_W        = 8,
    parameter int SUB_W         = 8,
    parameter int COARSE_W      = 4,
    parameter int IDLE_TICKS    = 55,
    parameter int START_MAX     = 17,
    parameter int COARSE_LIMIT  = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ir_line,
    output logic [OUT_W-1:0] cmd_code,
    output logic [OUT_W-1:0] sys_code,
    output logic             frame_done,
    output logic             frame_fault
);
    logic                line_s;
    logic                fine_clr, span_clr;
    logic [FINE_W-1:0]   fine;
    logic [COARSE_W-1:0] coarse;

    irdec_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ir_line),
        .dout (line_s)
    );

    irdec_timebase #(
        .CLKS_PER_TICK(CLKS_PER_TICK),
        .FINE_W       (FINE_W),
        .SUB_W        (SUB_W),
        .COARSE_W     (COARSE_W)
    ) u_tb (
        .clk     (clk),
        .rst_n   (rst_n),
        .fine_clr(fine_clr),
        .span_clr(span_clr),
        .fine    (fine),
        .coarse  (coarse)
    );

    irdec_fsm #(
        .FINE_W      (FINE_W),
        .COARSE_W    (COARSE_W),
        .IDLE_TICKS  (IDLE_TICKS),
        .START_MAX   (START_MAX),
        .COARSE_LIMIT(COARSE_LIMIT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .line       (line_s),
        .fine       (fine),
        .coarse     (coarse),
        .fine_clr   (fine_clr),
        .span_clr   (span_clr),
        .cmd_code   (cmd_code),
        .sys_code   (sys_code),
        .frame_done (frame_done),
        .frame_fault(frame_fault)
    );
endmodule

// File: rtl/irdec_checker.sv
// Cycle-level properties on the decoder's result interface.
// Assumes it is bound to ir_frame_decoder and sees only its ports.
module irdec_checker
    import irdec_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [OUT_W-1:0] cmd_code,
    input logic [OUT_W-1:0] sys_code,
    input logic             frame_done,
    input logic             frame_fault
);
    // R9: a result and a fault never share a cycle
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(frame_done && frame_fault));

    // R9: done lasts exactly one clock
    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    // R8: a fault presents all ones on both bytes
    a_r8_fault_ones: assert property (@(posedge clk) disable iff (!rst_n)
        frame_fault |-> (cmd_code == '1) && (sys_code == '1));

    // R8: fault lasts one clock and cannot be followed at once by a result
    a_r8_fault_single: assert property (@(posedge clk) disable iff (!rst_n)
        frame_fault |=> !frame_fault && !frame_done);

    // R6: a good result keeps the unused upper bits clear
    a_r6_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (cmd_code[OUT_W-1:CMD_W+1] == '0) &&
                       (sys_code[OUT_W-1:SYS_W] == '0));

    // R9: outputs move only in a result or fault cycle
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cmd_code, sys_code}) |-> (frame_done || frame_fault));
endmodule

bind ir_frame_decoder irdec_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_code   (cmd_code),
    .sys_code   (sys_code),
    .frame_done (frame_done),
    .frame_fault(frame_fault)
);

// File: tb/tb_ir_frame_decoder.sv
// Self-checking bench: directed timing corners plus random frames.
module tb_ir_frame_decoder;
    localparam int P = 4;            // clocks per tick in the bench
    localparam int SPAN = 2048;      // ticks before the attempt limit

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_line = 1'b1;
    logic [7:0] cmd_code, sys_code;
    logic       frame_done, frame_fault;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int n_done = 0, n_fault = 0, fault_cyc = 0, rel_cyc = 0;
    logic [7:0] d_cmd = 0, d_sys = 0, f_cmd = 0, f_sys = 0;

    always #2.5 clk = ~clk;

    ir_frame_decoder #(.CLKS_PER_TICK(P)) dut (
        .clk(clk), .rst_n(rst_n), .ir_line(ir_line),
        .cmd_code(cmd_code), .sys_code(sys_code),
        .frame_done(frame_done), .frame_fault(frame_fault)
    );

    // Record result and fault pulses away from the active edge.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (frame_done) begin
            n_done <= n_done + 1;
            d_cmd  <= cmd_code;
            d_sys  <= sys_code;
        end
        if (frame_fault) begin
            n_fault   <= n_fault + 1;
            fault_cyc <= cyc;
            f_cmd     <= cmd_code;
            f_sys     <= sys_code;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic drive(input bit lvl, input int ticks);
        @(negedge clk);
        ir_line = lvl;
        repeat (ticks * P - 1) @(negedge clk);
    endtask

    function automatic logic [7:0] exp_cmd(bit t, bit [5:0] c);
        return {1'b0, t, c};
    endfunction

    function automatic logic [7:0] exp_sys(bit [4:0] s);
        return {3'b000, s};
    endfunction

    // Start bits then twelve bits; bad_bit >= 0 drops that bit's mid edge.
    task automatic send_frame(input int h, input bit t, input bit [4:0] s,
                              input bit [5:0] c, input int bad_bit);
        logic [11:0] w;
        w = {t, s, c};
        drive(1'b0, h);
        drive(1'b1, h);
        drive(1'b0, h);
        for (int i = 0; i < 12; i++) begin
            if (i == bad_bit) begin
                drive(w[11-i], 3 * h);
                return;
            end
            drive(w[11-i], h);
            drive(!w[11-i], h);
        end
        drive(1'b1, 2);
    endtask

    task automatic good_frame(input int h, input int gap, input bit t,
                              input bit [4:0] s, input bit [5:0] c, input string req);
        int nd, nf;
        drive(1'b1, gap);
        nd = n_done; nf = n_fault;
        send_frame(h, t, s, c, -1);
        chk(n_done == nd + 1, req, "done count", n_done - nd, 1);
        chk(n_fault == nf, req, "no fault", n_fault - nf, 0);
        chk(d_cmd == exp_cmd(t, c), "R6", "cmd_code", d_cmd, exp_cmd(t, c));
        chk(d_sys == exp_sys(s), "R6", "sys_code", d_sys, exp_sys(s));
    endtask

    task automatic expect_fault(input int nf, input string req);
        chk(n_fault == nf + 1, req, "fault count", n_fault - nf, 1);
        chk(f_cmd == 8'hFF && f_sys == 8'hFF, "R8", "fault bytes",
            {f_cmd, f_sys}, 16'hFFFF);
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int nf, nd, first;
        void'($urandom(32'd4021));
        repeat (6) @(negedge clk);
        // R1: reset state
        chk(cmd_code == 0 && sys_code == 0, "R1", "bytes in reset", {cmd_code, sys_code}, 0);
        chk(!frame_done && !frame_fault, "R1", "pulses in reset", {frame_done, frame_fault}, 0);
        ir_line = 1'b0;
        rst_n = 1'b1;
        rel_cyc = cyc;
        repeat (4) @(negedge clk);
        chk(cmd_code == 0 && sys_code == 0 && !frame_done, "R1", "after release",
            {cmd_code, sys_code}, 0);

        // R3: line stuck low, then stuck high, each ends in a fault at the limit
        repeat ((SPAN + 8) * P) @(negedge clk);
        chk(n_fault == 1, "R3", "stuck-low fault count", n_fault, 1);
        first = fault_cyc - rel_cyc;
        chk(first >= (SPAN - 2) * P && first <= (SPAN + 2) * P, "R3",
            "stuck-low fault cycle", first, SPAN * P);
        expect_fault(0, "R3");
        ir_line = 1'b1;
        first = fault_cyc;
        repeat ((SPAN - 20) * P) @(negedge clk);
        chk(n_fault == 1, "R3", "no early fault", n_fault, 1);
        repeat (30 * P) @(negedge clk);
        chk(n_fault == 2 && (fault_cyc - first) >= (SPAN - 2) * P &&
            (fault_cyc - first) <= (SPAN + 2) * P, "R3", "stuck-high interval",
            fault_cyc - first, SPAN * P);

        // R6 R10: extremes of half-bit time and of field values
        good_frame(16, 70, 1'b1, 5'h1F, 6'h3F, "R10");
        good_frame(8, 70, 1'b0, 5'h00, 6'h00, "R10");
        good_frame(11, 70, 1'b1, 5'h0A, 6'h15, "R6");

        // R9: outputs hold while the line is quiet
        nd = n_done;
        drive(1'b1, 120);
        chk(cmd_code == exp_cmd(1'b1, 6'h15) && sys_code == exp_sys(5'h0A), "R9",
            "held bytes", {cmd_code, sys_code}, {exp_cmd(1'b1, 6'h15), exp_sys(5'h0A)});
        chk(n_done == nd, "R9", "no extra done", n_done - nd, 0);

        // R4: start low phase too long
        nf = n_fault;
        drive(1'b0, 20);
        expect_fault(nf, "R4");

        // R2: breaks in the quiet wait keep the next frame from being taken
        nf = n_fault; nd = n_done;
        drive(1'b0, 3);
        drive(1'b1, 40);
        drive(1'b0, 3);
        drive(1'b1, 40);
        send_frame(10, 1'b1, 5'h05, 6'h2A, -1);
        chk(n_done == nd && n_fault == nf, "R2", "unqualified frame ignored",
            (n_done - nd) + (n_fault - nf), 0);
        good_frame(10, 80, 1'b0, 5'h13, 6'h0C, "R2");

        // R5: high phase after the start low phase too long
        drive(1'b1, 80);
        nf = n_fault;
        drive(1'b0, 10);
        drive(1'b1, 30);
        expect_fault(nf, "R5");

        // R7: a bit with no mid-bit transition
        drive(1'b1, 80);
        nf = n_fault;
        send_frame(12, 1'b1, 5'h16, 6'h31, 5);
        expect_fault(nf, "R7");
        nf = n_fault;
        drive(1'b1, 80);
        send_frame(9, 1'b0, 5'h09, 6'h22, 11);
        expect_fault(nf, "R7");

        // R10: random frames back to back
        for (int k = 0; k < 14; k++) begin
            int h, g;
            bit t;
            bit [4:0] s;
            bit [5:0] c;
            h = 8 + int'($urandom % 9);
            g = 60 + int'($urandom % 100);
            t = 1'($urandom);
            s = 5'($urandom);
            c = 6'($urandom);
            good_frame(h, g, t, s, c, "R10");
        end
        finish_run();
    end
endmodule